// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It walks a two-level translation tree that lives in ordinary memory. A request carries the virtual address, a write flag and a user flag. The walker latches these together with the frame number of the root directory. It then fetches the directory word and, unless that word maps a 4 MB region directly, the second-level word. Every fetch and store goes through one memory port that has at most one access in flight.

Each level is checked for presence and for access rights as soon as its word arrives. A failed check ends the walk at once with a fault code, and nothing is written back. A walk that succeeds marks the words it used as accessed, and marks the final word as modified when the access is a write. Each mark is a store of the word read earlier with the needed bits ORed in. A store is issued only when a bit is actually clear. The result is one response pulse. It gives either the physical address with merged attributes, or a fault with its cause.

Top module: `ptw_walker`

## Requirements
- R1: Out of reset the walker is idle: `req_ready` is 1, and `mem_req_valid` and `rsp_valid` are 0.
- R2: For a small-page walk, the first read is at {root_frame, va[31:22], 2'b00}. The second read is at {directory word[31:12], va[21:12], 2'b00}. The physical address is {second word[31:12], va[11:0]}.
- R3: A directory word with bit 7 set maps a 4 MB page. The walk reads no second word, and the physical address is {directory word[31:22], va[21:0]}.
- R4: A word with bit 0 (present) clear, at either level, ends the walk with `rsp_fault`=1 and `rsp_cause[0]`=0.
- R5: A write needs bit 1 (writable) set in every word walked. A user access needs bit 2 (user) set in every word walked. A violation faults with `rsp_cause[0]`=1.
- R6: On a fault, `rsp_cause[1]` equals the write flag of the request and `rsp_cause[2]` equals its user flag.
- R7: After a successful walk, every word used has bit 5 (accessed) set. A word whose bit 5 was already set is not stored again unless R8 needs it.
- R8: A successful write walk leaves bit 6 (dirty) set in the final word. Accessed and dirty go out in a single store. A read walk leaves bit 6 unchanged.
- R9: A faulting walk issues no memory store.
- R10: `rsp_attr` has these bits. Bit 0 is writable, the AND over the levels. Bit 1 is user, the AND over the levels. Bit 2 is write-through and bit 3 is cache-disable, each the OR of bits 3 and 4 over the levels. Bit 4 is global, bit 8 of the final word.
- R11: While a walk runs, `req_ready` is 0. A memory request keeps address, direction and data stable until `mem_ack`. Each accepted request yields exactly one single-cycle `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request accepted on this edge |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user mode |
| root_frame | input | 20 | Frame number of the root directory |
| mem_req_valid | output | 1 | Memory access requested |
| mem_req_write | output | 1 | Memory access is a store |
| mem_req_addr | output | 32 | Byte address of the word |
| mem_req_wdata | output | 32 | Store data |
| mem_ack | input | 1 | Access completed; read data valid |
| mem_rdata | input | 32 | Read data |
| rsp_valid | output | 1 | Result pulse |
| rsp_fault | output | 1 | Walk ended in a fault |
| rsp_cause | output | 3 | {user, write, protection} fault code |
| rsp_paddr | output | 32 | Physical address when no fault |
| rsp_attr | output | 5 | {global, cache-disable, write-through, user, writable} |

## Verification
The hardest case to reach is a walk that gets past the directory and then faults at the second level. The directory word has a clear accessed bit, so a careless design would already have stored it. The stimulus sets up exactly that directory word. It then points it at a table word that is either absent or read-only, and counts the stores seen by the memory model. The no-store rule becomes visible at the port only because of this counting. Later walks repeat over the same words with their bits already set, and the store count must drop to zero or to a single dirty store. Some of these walks run with a slow memory, so that request stability is exercised across wait cycles.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int VA_W      = 32;
  localparam int OFF_W     = 12;
  localparam int IDX_W     = 10;
  localparam int FRM_W     = VA_W - OFF_W;
  localparam int BIG_OFF_W = OFF_W + IDX_W;
  localparam int ATTR_W    = 5;
  localparam int CAUSE_W   = 3;

  // entry property bit positions
  localparam int B_P   = 0;
  localparam int B_RW  = 1;
  localparam int B_US  = 2;
  localparam int B_WT  = 3;
  localparam int B_CD  = 4;
  localparam int B_ACC = 5;
  localparam int B_DRT = 6;
  localparam int B_BIG = 7;
  localparam int B_GLB = 8;

  // merged attribute positions
  localparam int A_RW  = 0;
  localparam int A_US  = 1;
  localparam int A_WT  = 2;
  localparam int A_CD  = 3;
  localparam int A_GLB = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DIR_RD, ST_TBL_RD, ST_DIR_WB, ST_LEAF_WB, ST_DONE
  } walk_st_t;
endpackage

// File: rtl/ptw_perm_chk.sv
module ptw_perm_chk (
  input  logic present,
  input  logic writable,
  input  logic user_ok,
  input  logic acc_write,
  input  logic acc_user,
  output logic miss,
  output logic deny
);
  assign miss = !present;
  assign deny = (acc_write && !writable) || (acc_user && !user_ok);
endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
  import ptw_pkg::*;
(
  input  logic [FRM_W-1:0] root_frm,
  input  logic [FRM_W-1:0] dir_frm,
  input  logic [IDX_W-1:0] dir_idx,
  input  logic [IDX_W-1:0] tbl_idx,
  output logic [VA_W-1:0]  dir_addr,
  output logic [VA_W-1:0]  tbl_addr
);
  assign dir_addr = {root_frm, dir_idx, 2'b00};
  assign tbl_addr = {dir_frm, tbl_idx, 2'b00};
endmodule

// File: rtl/ptw_merge.sv
module ptw_merge
  import ptw_pkg::*;
(
  input  logic [VA_W-1:0]   dir_ent,
  input  logic [VA_W-1:0]   leaf_ent,
  input  logic              big,
  input  logic [VA_W-1:0]   va,
  output logic [VA_W-1:0]   paddr,
  output logic [ATTR_W-1:0] attr
);
  logic unused_bits;
  assign unused_bits = ^{dir_ent[VA_W-1:B_CD+1], dir_ent[B_P],
                         leaf_ent[B_BIG:B_ACC], leaf_ent[OFF_W-1:B_GLB+1],
                         leaf_ent[B_P], va[VA_W-1:BIG_OFF_W]};

  always_comb begin
    if (big) paddr = {leaf_ent[VA_W-1:BIG_OFF_W], va[BIG_OFF_W-1:0]};
    else     paddr = {leaf_ent[VA_W-1:OFF_W], va[OFF_W-1:0]};
    attr[A_RW]  = dir_ent[B_RW] & leaf_ent[B_RW];
    attr[A_US]  = dir_ent[B_US] & leaf_ent[B_US];
    attr[A_WT]  = dir_ent[B_WT] | leaf_ent[B_WT];
    attr[A_CD]  = dir_ent[B_CD] | leaf_ent[B_CD];
    attr[A_GLB] = leaf_ent[B_GLB];
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [VA_W-1:0]    req_vaddr,
  input  logic               req_write,
  input  logic               req_user,
  input  logic [FRM_W-1:0]   root_frame,
  output logic               mem_req_valid,
  output logic               mem_req_write,
  output logic [VA_W-1:0]    mem_req_addr,
  output logic [VA_W-1:0]    mem_req_wdata,
  input  logic               mem_ack,
  input  logic [VA_W-1:0]    mem_rdata,
  output logic               rsp_valid,
  output logic               rsp_fault,
  output logic [CAUSE_W-1:0] rsp_cause,
  output logic [ATTR_W-1:0]  rsp_attr,
  output logic [VA_W-1:0]    rsp_paddr
);
  localparam logic [VA_W-1:0] ACC_MASK = VA_W'(1) << B_ACC;
  localparam logic [VA_W-1:0] DRT_MASK = VA_W'(1) << B_DRT;

  walk_st_t st_q, st_d;
  logic [VA_W-1:0]    va_q, dir_q, leaf_q;
  logic [FRM_W-1:0]   root_q;
  logic               wr_q, usr_q, big_q, flt_q;
  logic [CAUSE_W-1:0] cause_q, cause_d;
  logic               cap_en, dir_en, leaf_en, flt_en, flt_d;
  logic               dmiss, ddeny, tmiss, tdeny;
  logic [VA_W-1:0]    dir_addr, tbl_addr;

  function automatic logic leaf_need(input logic [VA_W-1:0] e, input logic w);
    return !e[B_ACC] || (w && !e[B_DRT]);
  endfunction

  ptw_perm_chk u_dir_chk (
    .present (mem_rdata[B_P]), .writable (mem_rdata[B_RW]), .user_ok (mem_rdata[B_US]),
    .acc_write (wr_q), .acc_user (usr_q), .miss (dmiss), .deny (ddeny));

  ptw_perm_chk u_tbl_chk (
    .present (mem_rdata[B_P]),
    .writable (dir_q[B_RW] & mem_rdata[B_RW]),
    .user_ok (dir_q[B_US] & mem_rdata[B_US]),
    .acc_write (wr_q), .acc_user (usr_q), .miss (tmiss), .deny (tdeny));

  ptw_addr_gen u_addr (
    .root_frm (root_q), .dir_frm (dir_q[VA_W-1:OFF_W]),
    .dir_idx (va_q[VA_W-1:BIG_OFF_W]), .tbl_idx (va_q[BIG_OFF_W-1:OFF_W]),
    .dir_addr (dir_addr), .tbl_addr (tbl_addr));

  ptw_merge u_merge (
    .dir_ent (dir_q), .leaf_ent (leaf_q), .big (big_q), .va (va_q),
    .paddr (rsp_paddr), .attr (rsp_attr));

  // next state
  always_comb begin
    st_d    = st_q;
    cap_en  = 1'b0;
    dir_en  = 1'b0;
    leaf_en = 1'b0;
    flt_en  = 1'b0;
    flt_d   = 1'b0;
    cause_d = cause_q;
    case (st_q)
      ST_IDLE: if (req_valid) begin
        cap_en = 1'b1;
        flt_en = 1'b1;
        st_d   = ST_DIR_RD;
      end
      ST_DIR_RD: if (mem_ack) begin
        dir_en  = 1'b1;
        leaf_en = 1'b1;
        if (dmiss || ddeny) begin
          flt_en  = 1'b1;
          flt_d   = 1'b1;
          cause_d = {usr_q, wr_q, !dmiss};
          st_d    = ST_DONE;
        end else if (mem_rdata[B_BIG]) begin
          st_d = leaf_need(mem_rdata, wr_q) ? ST_LEAF_WB : ST_DONE;
        end else begin
          st_d = ST_TBL_RD;
        end
      end
      ST_TBL_RD: if (mem_ack) begin
        leaf_en = 1'b1;
        if (tmiss || tdeny) begin
          flt_en  = 1'b1;
          flt_d   = 1'b1;
          cause_d = {usr_q, wr_q, !tmiss};
          st_d    = ST_DONE;
        end else if (!dir_q[B_ACC]) begin
          st_d = ST_DIR_WB;
        end else begin
          st_d = leaf_need(mem_rdata, wr_q) ? ST_LEAF_WB : ST_DONE;
        end
      end
      ST_DIR_WB:  if (mem_ack) st_d = leaf_need(leaf_q, wr_q) ? ST_LEAF_WB : ST_DONE;
      ST_LEAF_WB: if (mem_ack) st_d = ST_DONE;
      ST_DONE:    st_d = ST_IDLE;
      default:    st_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      va_q    <= '0;
      root_q  <= '0;
      wr_q    <= 1'b0;
      usr_q   <= 1'b0;
      dir_q   <= '0;
      leaf_q  <= '0;
      big_q   <= 1'b0;
      flt_q   <= 1'b0;
      cause_q <= '0;
    end else begin
      st_q <= st_d;
      if (cap_en) begin
        va_q   <= req_vaddr;
        root_q <= root_frame;
        wr_q   <= req_write;
        usr_q  <= req_user;
      end
      if (dir_en) begin
        dir_q <= mem_rdata;
        big_q <= mem_rdata[B_BIG];
      end
      if (leaf_en) leaf_q <= mem_rdata;
      if (flt_en) begin
        flt_q   <= flt_d;
        cause_q <= cause_d;
      end
    end
  end

  // outputs
  always_comb begin
    req_ready     = (st_q == ST_IDLE);
    rsp_valid     = (st_q == ST_DONE);
    rsp_fault     = flt_q;
    rsp_cause     = cause_q;
    mem_req_valid = (st_q == ST_DIR_RD) || (st_q == ST_TBL_RD) ||
                    (st_q == ST_DIR_WB) || (st_q == ST_LEAF_WB);
    mem_req_write = (st_q == ST_DIR_WB) || (st_q == ST_LEAF_WB);
    mem_req_addr  = '0;
    mem_req_wdata = '0;
    case (st_q)
      ST_DIR_RD: mem_req_addr = dir_addr;
      ST_TBL_RD: mem_req_addr = tbl_addr;
      ST_DIR_WB: begin
        mem_req_addr  = dir_addr;
        mem_req_wdata = dir_q | ACC_MASK;
      end
      ST_LEAF_WB: begin
        mem_req_addr  = big_q ? dir_addr : tbl_addr;
        mem_req_wdata = leaf_q | ACC_MASK | (wr_q ? DRT_MASK : '0);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk
  import ptw_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic               req_write,
  input logic               req_user,
  input logic               mem_req_valid,
  input logic               mem_req_write,
  input logic [VA_W-1:0]    mem_req_addr,
  input logic [VA_W-1:0]    mem_req_wdata,
  input logic               mem_ack,
  input logic               rsp_valid,
  input logic               rsp_fault,
  input logic [CAUSE_W-1:0] rsp_cause
);
  logic cap_w, cap_u;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_w <= 1'b0;
      cap_u <= 1'b0;
    end else if (req_valid && req_ready) begin
      cap_w <= req_write;
      cap_u <= req_user;
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req_valid && !rsp_valid);

  p_req_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_ack |=> mem_req_valid && $stable(mem_req_addr) &&
      $stable(mem_req_write) && $stable(mem_req_wdata));

  p_rsp_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid && req_ready);

  p_store_marks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_write |-> mem_req_wdata[B_ACC]);

  p_cause_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> rsp_cause[1] == cap_w && rsp_cause[2] == cap_u);
endmodule

bind ptw_walker ptw_walker_chk u_chk (
  .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_ready (req_ready),
  .req_write (req_write), .req_user (req_user), .mem_req_valid (mem_req_valid),
  .mem_req_write (mem_req_write), .mem_req_addr (mem_req_addr),
  .mem_req_wdata (mem_req_wdata), .mem_ack (mem_ack), .rsp_valid (rsp_valid),
  .rsp_fault (rsp_fault), .rsp_cause (rsp_cause));

// File: tb/ptw_walker_bench.sv
module ptw_walker_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_write, req_user;
  logic [31:0] req_vaddr;
  logic [19:0] root_frame;
  logic        mem_req_valid, mem_req_write, mem_ack;
  logic [31:0] mem_req_addr, mem_req_wdata, mem_rdata;
  logic        rsp_valid, rsp_fault;
  logic [2:0]  rsp_cause;
  logic [4:0]  rsp_attr;
  logic [31:0] rsp_paddr;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptw_walker u_ptw_walker (
    .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_ready (req_ready),
    .req_vaddr (req_vaddr), .req_write (req_write), .req_user (req_user),
    .root_frame (root_frame), .mem_req_valid (mem_req_valid),
    .mem_req_write (mem_req_write), .mem_req_addr (mem_req_addr),
    .mem_req_wdata (mem_req_wdata), .mem_ack (mem_ack), .mem_rdata (mem_rdata),
    .rsp_valid (rsp_valid), .rsp_fault (rsp_fault), .rsp_cause (rsp_cause),
    .rsp_attr (rsp_attr), .rsp_paddr (rsp_paddr));

  // memory model: 16 KB of words, programmable wait cycles
  logic [31:0] mem [0:4095];
  int lat, wcnt, wr_cnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack   <= 1'b0;
      mem_rdata <= '0;
      wcnt      <= 0;
    end else if (mem_ack) begin
      mem_ack <= 1'b0;
    end else if (mem_req_valid) begin
      if (wcnt >= lat) begin
        wcnt      <= 0;
        mem_ack   <= 1'b1;
        mem_rdata <= mem[mem_req_addr[13:2]];
        if (mem_req_write) begin
          mem[mem_req_addr[13:2]] <= mem_req_wdata;
          wr_cnt <= wr_cnt + 1;
        end
      end else begin
        wcnt <= wcnt + 1;
      end
    end
  end

  typedef struct {
    logic        fault;
    logic [2:0]  cause;
    logic [31:0] pa;
    logic [4:0]  attr;
    string       tag;
  } exp_t;

  exp_t sb[$];
  exp_t mon_e;
  int checks = 0, errors = 0, n_rsp = 0, n_sent = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expectations as results appear
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R11 unexpected response", 32'(rsp_valid), 32'h0);
      end else begin
        mon_e = sb.pop_front();
        chk(rsp_fault == mon_e.fault, {mon_e.tag, " fault"}, 32'(rsp_fault), 32'(mon_e.fault));
        if (mon_e.fault)
          chk(rsp_cause == mon_e.cause, {mon_e.tag, " cause"}, 32'(rsp_cause), 32'(mon_e.cause));
        else begin
          chk(rsp_paddr == mon_e.pa, {mon_e.tag, " paddr"}, rsp_paddr, mon_e.pa);
          chk(rsp_attr == mon_e.attr, {mon_e.tag, " attr"}, 32'(rsp_attr), 32'(mon_e.attr));
        end
      end
      n_rsp++;
    end
  end

  task automatic walk(input logic [31:0] va, input logic w, input logic u,
                      input logic f, input logic [2:0] cause, input logic [31:0] pa,
                      input logic [4:0] attr, input int exp_wr, input string tag);
    exp_t e;
    int base;
    e.fault = f; e.cause = cause; e.pa = pa; e.attr = attr; e.tag = tag;
    sb.push_back(e);
    base = wr_cnt;
    n_sent++;
    @(negedge clk);
    req_vaddr = va; req_write = w; req_user = u; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, {tag, " R11 busy"}, 32'(req_ready), 32'h0);
    wait (n_rsp == n_sent);
    @(negedge clk);
    chk(wr_cnt - base == exp_wr, {tag, " store count"}, 32'(wr_cnt - base), 32'(exp_wr));
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    wr_cnt = 0; lat = 0;
    req_valid = 0; req_write = 0; req_user = 0; req_vaddr = '0;
    root_frame = 20'h00001;
    // directory at 0x1000, tables at 0x2000 and 0x3000
    mem['h1004 >> 2] = 32'h0000_2007;
    mem['h200C >> 2] = 32'h1234_5003;
    mem['h1014 >> 2] = 32'hE940_0087;
    mem['h101C >> 2] = 32'h0000_0000;
    mem['h1020 >> 2] = 32'h0000_3007;
    mem['h3000 >> 2] = 32'h0007_7006;
    mem['h1024 >> 2] = 32'h0000_3027;
    mem['h3004 >> 2] = 32'h0005_5005;
    mem['h1028 >> 2] = 32'h0000_3003;
    mem['h3008 >> 2] = 32'h0006_6007;
    mem['h102C >> 2] = 32'h0000_301F;
    mem['h3010 >> 2] = 32'hABCD_E127;
    mem['h1030 >> 2] = 32'h0000_3005;
    mem['h3014 >> 2] = 32'h0008_8007;
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", 32'(req_ready), 32'h1);
    chk(mem_req_valid == 1'b0, "R1 no memory request", 32'(mem_req_valid), 32'h0);
    chk(rsp_valid == 1'b0, "R1 no response", 32'(rsp_valid), 32'h0);
    rst_n = 1;
    @(negedge clk);

    // R2 R7 small page read: both accessed bits clear -> two stores
    walk(32'h0040_3ABC, 0, 0, 0, 3'b000, 32'h1234_5ABC, 5'b00001, 2, "R2 R7 small read");
    chk(mem['h1004 >> 2] == 32'h0000_2027, "R7 dir accessed", mem['h1004 >> 2], 32'h0000_2027);
    chk(mem['h200C >> 2] == 32'h1234_5023, "R8 read keeps dirty clear", mem['h200C >> 2], 32'h1234_5023);
    // R7 repeat: bits already set -> no store
    walk(32'h0040_3ABC, 0, 0, 0, 3'b000, 32'h1234_5ABC, 5'b00001, 0, "R7 no redundant store");
    // R8 write: dirty set in one store
    lat = 2;
    walk(32'h0040_3ABC, 1, 0, 0, 3'b000, 32'h1234_5ABC, 5'b00001, 1, "R8 write sets dirty");
    chk(mem['h200C >> 2] == 32'h1234_5063, "R8 leaf dirty", mem['h200C >> 2], 32'h1234_5063);
    walk(32'h0040_3ABC, 1, 0, 0, 3'b000, 32'h1234_5ABC, 5'b00001, 0, "R8 dirty already set");
    // R3 large page user write: accessed+dirty in one store
    lat = 0;
    walk(32'h0141_2345, 1, 1, 0, 3'b000, 32'hE941_2345, 5'b00011, 1, "R3 large page");
    chk(mem['h1014 >> 2] == 32'hE940_00E7, "R3 R8 large entry marks", mem['h1014 >> 2], 32'hE940_00E7);
    // R4 absent directory word, user read
    walk(32'h01C0_0000, 0, 1, 1, 3'b100, 32'h0, 5'b0, 0, "R4 R6 R9 dir absent");
    // R4 absent table word after good directory with accessed clear
    walk(32'h0200_0000, 1, 0, 1, 3'b010, 32'h0, 5'b0, 0, "R4 R9 table absent");
    chk(mem['h1020 >> 2] == 32'h0000_3007, "R9 dir untouched", mem['h1020 >> 2], 32'h0000_3007);
    // R5 user write to read-only table word
    walk(32'h0240_1000, 1, 1, 1, 3'b111, 32'h0, 5'b0, 0, "R5 R6 read-only");
    // R5 user read through supervisor directory
    walk(32'h0280_2000, 0, 1, 1, 3'b101, 32'h0, 5'b0, 0, "R5 supervisor dir");
    chk(mem['h3008 >> 2] == 32'h0006_6007, "R9 table untouched", mem['h3008 >> 2], 32'h0006_6007);
    // R10 attribute merge, slow memory
    lat = 3;
    walk(32'h02C0_43F0, 0, 0, 0, 3'b000, 32'hABCD_E3F0, 5'b11111, 1, "R10 merge attrs");
    // R5 supervisor write blocked by read-only directory
    lat = 1;
    walk(32'h0300_5000, 1, 0, 1, 3'b011, 32'h0, 5'b0, 0, "R5 R9 dir read-only");
    // R10 user read through it: writable ANDs to 0
    walk(32'h0300_5000, 0, 1, 0, 3'b000, 32'h0008_8000, 5'b00010, 2, "R10 R2 and rule");

    chk(sb.size() == 0, "R11 all responses seen", 32'(sb.size()), 32'h0);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R11 watchdog expired actual=%h expected=%h", n_rsp, n_sent);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule